// File: doc/BRIEF.md
# Floating-point store issue controller

This block runs one floating-point register store at a time inside a load/store unit. A decoded request arrives with its qualifying predicate, its form flags (register spill, integer image, base register post-update), a format code, the base address and its NaT bit, a flag saying the source FP register holds NaTVal, a flag saying that register is disabled, a flag saying the update target register is invalid, and a 9-bit signed post-update immediate.

The controller first runs the checks that need no external help and reports the first fault that matches. If none matches, it asks an external translator for the physical address and an external converter for the memory image of the data. It then issues the memory write and, once that write is accepted, asks for an invalidate of every advanced-load table entry that overlaps the bytes written. In the post-update form it then writes back the base register. Every external port uses a valid/ready handshake, and a new request is taken only after the current one has reported.

Top module: `fpst_issue_ctrl`

## Requirements
- R1: A request with `req_qp` low reports `done` with `fault_code` 0. It makes no translation, conversion, memory write, invalidate or writeback request, whatever its other fields hold.
- R2: With `req_bupd` high and `req_tgt_bad` high, the request reports `fault_code` 1 (illegal operation). This check outranks every other check. `req_tgt_bad` is ignored when `req_bupd` is low.
- R3: Otherwise, `req_reg_dis` high reports `fault_code` 2 (disabled FP register). This check outranks the NaT check.
- R4: Otherwise, the request reports `fault_code` 3 (register NaT consumption) when `req_base_nat` is high, or when `req_spill` is low and `req_data_natval` is high. A spill store ignores `req_data_natval`.
- R5: The access size in bytes, given on `xl_size`, `cv_size` and `mw_size`, is 16 for a spill and 8 for the integer form. For any other store it follows `req_fmt`: 2'b00 gives 4, 2'b01 gives 8, and 2'b10 or 2'b11 gives 10.
- R6: `xl_uncache` and `mw_uncache` are high exactly when the access size is 10 bytes. Every memory request the block makes is a write.
- R7: The memory write carries the physical address returned by translation and the data returned by conversion. After that write is accepted, exactly one invalidate request is issued, with the same address and size.
- R8: In the post-update form, on success, `wb_valid` pulses with `done`. It carries `wb_data` = base + the immediate sign-extended from 9 bits (modulo 2^64) and `wb_nat` = 0. Without post-update, or after any fault, there is no writeback.
- R9: A translation response with `xl_rsp_fault` high reports `fault_code` 4. The request then makes no conversion, memory write, invalidate or writeback.
- R10: A request that faults under R2, R3 or R4 makes no translation request.
- R11: `req_ready` is high only while the block is idle and drops the cycle after a request is accepted. Each outgoing valid, together with its payload, holds until its ready is seen.
- R12: Each accepted request produces exactly one single-cycle `done` pulse, one cycle before `req_ready` rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to accept |
| req_qp | input | 1 | Qualifying predicate value |
| req_spill | input | 1 | Register spill form |
| req_intform | input | 1 | Integer image form |
| req_bupd | input | 1 | Base register post-update form |
| req_fmt | input | 2 | Format code (00 single, 01 double, 1x extended) |
| req_base | input | ADDR_W | Base register value |
| req_base_nat | input | 1 | Base register NaT bit |
| req_data_natval | input | 1 | Source FP register holds NaTVal |
| req_reg_dis | input | 1 | Source FP register disabled |
| req_tgt_bad | input | 1 | Post-update target register invalid |
| req_imm | input | IMM_W | Post-update immediate, two's complement |
| xl_valid | output | 1 | Translation request valid |
| xl_ready | input | 1 | Translation request accepted |
| xl_vaddr | output | ADDR_W | Virtual address to translate |
| xl_size | output | 5 | Access size in bytes |
| xl_uncache | output | 1 | Uncacheable hint for this write |
| xl_rsp_valid | input | 1 | Translation response valid |
| xl_rsp_fault | input | 1 | Translation raised a fault |
| xl_rsp_paddr | input | ADDR_W | Physical address |
| cv_valid | output | 1 | Conversion request valid |
| cv_ready | input | 1 | Conversion request accepted |
| cv_size | output | 5 | Memory image size in bytes |
| cv_intform | output | 1 | Convert as integer image |
| cv_spill | output | 1 | Convert as full spill image |
| cv_rsp_valid | input | 1 | Conversion response valid |
| cv_rsp_data | input | DATA_W | Memory image of the data |
| mw_valid | output | 1 | Memory write valid |
| mw_ready | input | 1 | Memory write accepted |
| mw_addr | output | ADDR_W | Physical write address |
| mw_size | output | 5 | Write size in bytes |
| mw_uncache | output | 1 | Uncacheable hint |
| mw_data | output | DATA_W | Write data |
| ai_valid | output | 1 | Advanced-load table invalidate valid |
| ai_ready | input | 1 | Invalidate accepted |
| ai_addr | output | ADDR_W | Start of the range to invalidate |
| ai_size | output | 5 | Length of the range in bytes |
| wb_valid | output | 1 | Base register writeback |
| wb_data | output | ADDR_W | Updated base value |
| wb_nat | output | 1 | NaT bit written with the base |
| done | output | 1 | Request finished (one cycle) |
| fault_code | output | 3 | 0 none, 1 illegal op, 2 FP disabled, 3 NaT consumption, 4 translation |

## Verification
The bench goes after the priority chain by setting several fault conditions in one request. A design with the wrong order would report the lower-ranked code. It also sets the target-invalid flag without post-update, where a careless decoder would raise an illegal-operation fault. A spill that carries a NaTVal source must still go through, and a spill with a NaT base must still fault, which catches a NaT check that ignores or over-applies the spill exemption. Format code 2'b11, the 10-byte uncacheable hint, a negative immediate, and a positive immediate that wraps the 64-bit base are exercised too, along with a translation fault on a post-update store, which must leave the base untouched. Some requests run with every ready toggling, to show the results do not depend on backpressure.

// File: rtl/fpst_pkg.sv
package fpst_pkg;

    localparam int SZ_W = 5;

    typedef enum logic [2:0] {
        FLT_NONE  = 3'd0,
        FLT_ILLOP = 3'd1,
        FLT_FPDIS = 3'd2,
        FLT_NATC  = 3'd3,
        FLT_XLATE = 3'd4
    } fault_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_XREQ,
        S_XWAIT,
        S_CREQ,
        S_CWAIT,
        S_MWR,
        S_INV,
        S_RPT
    } state_e;

    typedef logic [1:0] fmt_t;
    localparam fmt_t FMT_SGL = 2'b00;
    localparam fmt_t FMT_DBL = 2'b01;

    typedef struct packed {
        logic qp;
        logic spill;
        logic intf;
        logic bupd;
        fmt_t fmt;
    } form_t;

    typedef struct packed {
        logic base_nat;
        logic data_natval;
        logic reg_dis;
        logic tgt_bad;
    } chk_t;

    // Byte count of the access for a given form.
    function automatic logic [SZ_W-1:0] access_bytes(input form_t f);
        if (f.spill)
            return SZ_W'(16);
        else if (f.intf)
            return SZ_W'(8);
        else begin
            case (f.fmt)
                FMT_SGL: return SZ_W'(4);
                FMT_DBL: return SZ_W'(8);
                default: return SZ_W'(10);
            endcase
        end
    endfunction

    function automatic logic is_uncache(input logic [SZ_W-1:0] nbytes);
        return nbytes == SZ_W'(10);
    endfunction

endpackage

// File: rtl/fpst_precheck.sv
module fpst_precheck
    import fpst_pkg::*;
(
    input  form_t             form_i,
    input  chk_t              chk_i,
    output fault_e            fault_o,
    output logic [SZ_W-1:0]   bytes_o
);

    // Checks that need no external unit, highest priority first.
    always_comb begin
        fault_o = FLT_NONE;
        if (form_i.bupd && chk_i.tgt_bad)
            fault_o = FLT_ILLOP;
        else if (chk_i.reg_dis)
            fault_o = FLT_FPDIS;
        else if (chk_i.base_nat || (!form_i.spill && chk_i.data_natval))
            fault_o = FLT_NATC;
    end

    assign bytes_o = access_bytes(form_i);

endmodule

// File: rtl/fpst_wbcalc.sv
module fpst_wbcalc #(
    parameter int ADDR_W = 64,
    parameter int IMM_W  = 9
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [IMM_W-1:0]  imm_i,
    output logic [ADDR_W-1:0] sum_o
);

    localparam int EXT_W = (IMM_W < ADDR_W) ? (ADDR_W - IMM_W) : 1;

    generate
        if (IMM_W < ADDR_W) begin : g_ext
            assign sum_o = base_i + {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
        end else begin : g_trunc
            assign sum_o = base_i + imm_i[ADDR_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/fpst_seq.sv
module fpst_seq
    import fpst_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    input  logic   req_qp,
    input  fault_e early_fault,
    input  logic   xl_ready,
    input  logic   xl_rsp_valid,
    input  logic   xl_rsp_fault,
    input  logic   cv_ready,
    input  logic   cv_rsp_valid,
    input  logic   mw_ready,
    input  logic   ai_ready,
    output state_e state_o,
    output fault_e fault_o,
    output logic   req_ready,
    output logic   xl_valid,
    output logic   cv_valid,
    output logic   mw_valid,
    output logic   ai_valid,
    output logic   done,
    output logic   ld_req,
    output logic   ld_paddr,
    output logic   ld_data
);

    state_e st;
    fault_e fault_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            fault_q <= FLT_NONE;
        end else begin
            case (st)
                S_IDLE: if (req_valid) begin
                    fault_q <= req_qp ? early_fault : FLT_NONE;
                    st      <= (!req_qp || early_fault != FLT_NONE) ? S_RPT : S_XREQ;
                end
                S_XREQ:  if (xl_ready) st <= S_XWAIT;
                S_XWAIT: if (xl_rsp_valid) begin
                    if (xl_rsp_fault) begin
                        fault_q <= FLT_XLATE;
                        st      <= S_RPT;
                    end else begin
                        st      <= S_CREQ;
                    end
                end
                S_CREQ:  if (cv_ready) st <= S_CWAIT;
                S_CWAIT: if (cv_rsp_valid) st <= S_MWR;
                S_MWR:   if (mw_ready) st <= S_INV;
                S_INV:   if (ai_ready) st <= S_RPT;
                S_RPT:   st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        req_ready = (st == S_IDLE);
        xl_valid  = (st == S_XREQ);
        cv_valid  = (st == S_CREQ);
        mw_valid  = (st == S_MWR);
        ai_valid  = (st == S_INV);
        done      = (st == S_RPT);
        ld_req    = (st == S_IDLE) && req_valid;
        ld_paddr  = (st == S_XWAIT) && xl_rsp_valid && !xl_rsp_fault;
        ld_data   = (st == S_CWAIT) && cv_rsp_valid;
    end

    assign state_o = st;
    assign fault_o = fault_q;

endmodule

// File: rtl/fpst_issue_ctrl.sv
module fpst_issue_ctrl
    import fpst_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 128,
    parameter int IMM_W  = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_qp,
    input  logic              req_spill,
    input  logic              req_intform,
    input  logic              req_bupd,
    input  logic [1:0]        req_fmt,
    input  logic [ADDR_W-1:0] req_base,
    input  logic              req_base_nat,
    input  logic              req_data_natval,
    input  logic              req_reg_dis,
    input  logic              req_tgt_bad,
    input  logic [IMM_W-1:0]  req_imm,
    output logic              xl_valid,
    input  logic              xl_ready,
    output logic [ADDR_W-1:0] xl_vaddr,
    output logic [SZ_W-1:0]   xl_size,
    output logic              xl_uncache,
    input  logic              xl_rsp_valid,
    input  logic              xl_rsp_fault,
    input  logic [ADDR_W-1:0] xl_rsp_paddr,
    output logic              cv_valid,
    input  logic              cv_ready,
    output logic [SZ_W-1:0]   cv_size,
    output logic              cv_intform,
    output logic              cv_spill,
    input  logic              cv_rsp_valid,
    input  logic [DATA_W-1:0] cv_rsp_data,
    output logic              mw_valid,
    input  logic              mw_ready,
    output logic [ADDR_W-1:0] mw_addr,
    output logic [SZ_W-1:0]   mw_size,
    output logic              mw_uncache,
    output logic [DATA_W-1:0] mw_data,
    output logic              ai_valid,
    input  logic              ai_ready,
    output logic [ADDR_W-1:0] ai_addr,
    output logic [SZ_W-1:0]   ai_size,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_data,
    output logic              wb_nat,
    output logic              done,
    output logic [2:0]        fault_code
);

    form_t             in_form, form_q;
    chk_t              in_chk;
    fault_e            early_fault, fault_w;
    state_e            st_w;
    logic [SZ_W-1:0]   in_bytes, bytes_q;
    logic [ADDR_W-1:0] base_q, paddr_q, wb_sum;
    logic [IMM_W-1:0]  imm_q;
    logic [DATA_W-1:0] data_q;
    logic              ld_req, ld_paddr, ld_data;

    assign in_form = '{qp: req_qp, spill: req_spill, intf: req_intform,
                       bupd: req_bupd, fmt: req_fmt};
    assign in_chk  = '{base_nat: req_base_nat, data_natval: req_data_natval,
                       reg_dis: req_reg_dis, tgt_bad: req_tgt_bad};

    fpst_precheck u_precheck (
        .form_i  (in_form),
        .chk_i   (in_chk),
        .fault_o (early_fault),
        .bytes_o (in_bytes)
    );

    fpst_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_qp       (req_qp),
        .early_fault  (early_fault),
        .xl_ready     (xl_ready),
        .xl_rsp_valid (xl_rsp_valid),
        .xl_rsp_fault (xl_rsp_fault),
        .cv_ready     (cv_ready),
        .cv_rsp_valid (cv_rsp_valid),
        .mw_ready     (mw_ready),
        .ai_ready     (ai_ready),
        .state_o      (st_w),
        .fault_o      (fault_w),
        .req_ready    (req_ready),
        .xl_valid     (xl_valid),
        .cv_valid     (cv_valid),
        .mw_valid     (mw_valid),
        .ai_valid     (ai_valid),
        .done         (done),
        .ld_req       (ld_req),
        .ld_paddr     (ld_paddr),
        .ld_data      (ld_data)
    );

    fpst_wbcalc #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_wbcalc (
        .base_i (base_q),
        .imm_i  (imm_q),
        .sum_o  (wb_sum)
    );

    // Request, address and data holding registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            form_q  <= '0;
            bytes_q <= '0;
            base_q  <= '0;
            imm_q   <= '0;
            paddr_q <= '0;
            data_q  <= '0;
        end else begin
            if (ld_req) begin
                form_q  <= in_form;
                bytes_q <= in_bytes;
                base_q  <= req_base;
                imm_q   <= req_imm;
            end
            if (ld_paddr) paddr_q <= xl_rsp_paddr;
            if (ld_data)  data_q  <= cv_rsp_data;
        end
    end

    assign xl_vaddr   = base_q;
    assign xl_size    = bytes_q;
    assign xl_uncache = is_uncache(bytes_q);
    assign cv_size    = bytes_q;
    assign cv_intform = form_q.intf;
    assign cv_spill   = form_q.spill;
    assign mw_addr    = paddr_q;
    assign mw_size    = bytes_q;
    assign mw_uncache = is_uncache(bytes_q);
    assign mw_data    = data_q;
    assign ai_addr    = paddr_q;
    assign ai_size    = bytes_q;
    assign wb_valid   = done && form_q.qp && form_q.bupd && (fault_w == FLT_NONE);
    assign wb_data    = wb_sum;
    assign wb_nat     = 1'b0;
    assign fault_code = fault_w;

endmodule

// File: rtl/fpst_issue_ctrl_chk.sv
module fpst_issue_ctrl_chk
    import fpst_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input state_e            st,
    input logic              qp_q,
    input logic              xl_valid,
    input logic              xl_rsp_valid,
    input logic              xl_rsp_fault,
    input logic              mw_valid,
    input logic              mw_ready,
    input logic [ADDR_W-1:0] mw_addr,
    input logic [SZ_W-1:0]   mw_size,
    input logic              ai_valid,
    input logic [ADDR_W-1:0] ai_addr,
    input logic [SZ_W-1:0]   ai_size,
    input logic              wb_valid,
    input logic              done,
    input logic [2:0]        fault_code
);

    // R1: a false predicate leaves every downstream port idle
    p_quiet_pred_r1: assert property (@(posedge clk) disable iff (rst)
        (st != S_IDLE && !qp_q) |-> (!xl_valid && !mw_valid && !ai_valid && !wb_valid));

    // R5: write size is one of the legal byte counts
    p_size_legal_r5: assert property (@(posedge clk) disable iff (rst)
        mw_valid |-> (mw_size == 5'd4 || mw_size == 5'd8 || mw_size == 5'd10 || mw_size == 5'd16));

    // R7: accepted write is followed by an invalidate over the same range
    p_inval_follows_r7: assert property (@(posedge clk) disable iff (rst)
        (mw_valid && mw_ready) |=> (ai_valid && ai_addr == $past(mw_addr) && ai_size == $past(mw_size)));

    // R9: translation fault reports code 4 with no writeback
    p_xlate_fault_r9: assert property (@(posedge clk) disable iff (rst)
        (st == S_XWAIT && xl_rsp_valid && xl_rsp_fault) |=> (done && fault_code == 3'd4 && !wb_valid));

    // R11: write request holds while stalled
    p_mw_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_addr) && $stable(mw_size)));

    // R11: no second request while busy
    p_busy_r11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R12: done is a single-cycle pulse followed by idle
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && req_ready));

endmodule

bind fpst_issue_ctrl fpst_issue_ctrl_chk #(.ADDR_W(ADDR_W)) u_fpst_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .st           (st_w),
    .qp_q         (form_q.qp),
    .xl_valid     (xl_valid),
    .xl_rsp_valid (xl_rsp_valid),
    .xl_rsp_fault (xl_rsp_fault),
    .mw_valid     (mw_valid),
    .mw_ready     (mw_ready),
    .mw_addr      (mw_addr),
    .mw_size      (mw_size),
    .ai_valid     (ai_valid),
    .ai_addr      (ai_addr),
    .ai_size      (ai_size),
    .wb_valid     (wb_valid),
    .done         (done),
    .fault_code   (fault_code)
);

// File: tb/test_fpst_issue_ctrl.sv
module test_fpst_issue_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 15;

    typedef struct packed {
        logic        qp;
        logic        spill;
        logic        intf;
        logic        bupd;
        logic [1:0]  fmt;
        logic        bnat;
        logic        nval;
        logic        dis;
        logic        tbad;
        logic        xflt;
        logic [63:0] base;
        logic [8:0]  imm;
        logic [2:0]  efault;
        logic [4:0]  esize;
    } vec_t;

    // qp spill intf bupd fmt bnat nval dis tbad xflt base imm efault esize
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b0,1'b0,2'b00,1'b1,1'b0,1'b1,1'b0,1'b0,64'h0000_0000_0000_2000,9'h000,3'd0,5'd4},
        '{1'b1,1'b0,1'b0,1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,64'h0000_0000_0001_0040,9'h000,3'd0,5'd4},
        '{1'b1,1'b0,1'b0,1'b0,2'b01,1'b0,1'b0,1'b0,1'b0,1'b0,64'h0000_0000_0001_0080,9'h000,3'd0,5'd8},
        '{1'b1,1'b0,1'b0,1'b0,2'b10,1'b0,1'b0,1'b0,1'b0,1'b0,64'h0000_0000_0001_00c0,9'h000,3'd0,5'd10},
        '{1'b1,1'b0,1'b0,1'b0,2'b11,1'b0,1'b0,1'b0,1'b0,1'b0,64'h0000_0000_0001_0100,9'h000,3'd0,5'd10},
        '{1'b1,1'b0,1'b1,1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,64'h0000_0000_0001_0140,9'h000,3'd0,5'd8},
        '{1'b1,1'b1,1'b0,1'b0,2'b10,1'b0,1'b1,1'b0,1'b0,1'b0,64'h0000_0000_0001_0180,9'h000,3'd0,5'd16},
        '{1'b1,1'b0,1'b0,1'b1,2'b01,1'b0,1'b0,1'b0,1'b0,1'b0,64'h0000_0000_0000_0100,9'h1F0,3'd0,5'd8},
        '{1'b1,1'b0,1'b0,1'b1,2'b01,1'b0,1'b0,1'b0,1'b0,1'b0,64'hFFFF_FFFF_FFFF_FF80,9'h0FF,3'd0,5'd8},
        '{1'b1,1'b0,1'b0,1'b1,2'b00,1'b1,1'b1,1'b1,1'b1,1'b0,64'h0000_0000_0000_0200,9'h004,3'd1,5'd4},
        '{1'b1,1'b0,1'b0,1'b0,2'b00,1'b1,1'b0,1'b1,1'b1,1'b0,64'h0000_0000_0000_0240,9'h000,3'd2,5'd4},
        '{1'b1,1'b0,1'b0,1'b1,2'b00,1'b1,1'b0,1'b0,1'b0,1'b0,64'h0000_0000_0000_0280,9'h008,3'd3,5'd4},
        '{1'b1,1'b0,1'b0,1'b0,2'b01,1'b0,1'b1,1'b0,1'b0,1'b0,64'h0000_0000_0000_02c0,9'h000,3'd3,5'd8},
        '{1'b1,1'b0,1'b0,1'b1,2'b01,1'b0,1'b0,1'b0,1'b0,1'b1,64'hF000_0000_0000_0300,9'h010,3'd4,5'd8},
        '{1'b1,1'b1,1'b0,1'b0,2'b00,1'b1,1'b0,1'b0,1'b0,1'b0,64'h0000_0000_0000_0340,9'h000,3'd3,5'd16}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0, req_ready;
    logic         req_qp = 1'b0, req_spill = 1'b0, req_intform = 1'b0, req_bupd = 1'b0;
    logic [1:0]   req_fmt = 2'b00;
    logic [63:0]  req_base = '0;
    logic         req_base_nat = 1'b0, req_data_natval = 1'b0, req_reg_dis = 1'b0, req_tgt_bad = 1'b0;
    logic [8:0]   req_imm = '0;
    logic         xl_valid, xl_ready = 1'b1, xl_uncache;
    logic [63:0]  xl_vaddr;
    logic [4:0]   xl_size;
    logic         xl_rsp_valid = 1'b0, xl_rsp_fault = 1'b0;
    logic [63:0]  xl_rsp_paddr = '0;
    logic         cv_valid, cv_ready = 1'b1, cv_intform, cv_spill;
    logic [4:0]   cv_size;
    logic         cv_rsp_valid = 1'b0;
    logic [127:0] cv_rsp_data = '0;
    logic         mw_valid, mw_ready = 1'b1, mw_uncache;
    logic [63:0]  mw_addr;
    logic [4:0]   mw_size;
    logic [127:0] mw_data;
    logic         ai_valid, ai_ready = 1'b1;
    logic [63:0]  ai_addr;
    logic [4:0]   ai_size;
    logic         wb_valid, wb_nat, done;
    logic [63:0]  wb_data;
    logic [2:0]   fault_code;

    fpst_issue_ctrl i_fpst_issue_ctrl (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int nchk = 0, nfail = 0;

    // Responder and monitor state
    logic         stall = 1'b0, rdy = 1'b1, xflt_mode = 1'b0;
    logic         xl_pend = 1'b0, cv_pend = 1'b0;
    logic [63:0]  xl_va = '0;
    logic [4:0]   xl_sz = '0, cv_sz = '0, mw_sz = '0, ai_sz = '0;
    logic         xl_uc = 1'b0, cv_i = 1'b0, cv_s = 1'b0, mw_uc = 1'b0, wb_n = 1'b0;
    logic [63:0]  mw_a = '0, ai_a = '0, wb_d = '0;
    logic [127:0] mw_d = '0;
    logic [2:0]   last_fault = '0;
    int xl_cnt = 0, mw_cnt = 0, ai_cnt = 0, wb_cnt = 0, done_cnt = 0;

    function automatic logic [63:0] xlat(input logic [63:0] va);
        return va ^ 64'h0000_0F00_0000_0000;
    endfunction

    function automatic logic [127:0] conv(input logic [4:0] sz, input logic i, input logic s);
        return {64'hC0DE_0000_0000_0000 | {59'd0, sz}, 62'd0, s, i};
    endfunction

    always @(posedge clk) begin
        if (xl_valid && xl_ready) begin
            xl_pend = 1'b1; xl_va = xl_vaddr; xl_sz = xl_size; xl_uc = xl_uncache; xl_cnt++;
        end
        if (cv_valid && cv_ready) begin
            cv_pend = 1'b1; cv_sz = cv_size; cv_i = cv_intform; cv_s = cv_spill;
        end
        if (mw_valid && mw_ready) begin
            mw_cnt++; mw_a = mw_addr; mw_sz = mw_size; mw_uc = mw_uncache; mw_d = mw_data;
        end
        if (ai_valid && ai_ready) begin
            ai_cnt++; ai_a = ai_addr; ai_sz = ai_size;
        end
        if (wb_valid) begin
            wb_cnt++; wb_d = wb_data; wb_n = wb_nat;
        end
        if (done) begin
            done_cnt++; last_fault = fault_code;
        end
    end

    always @(negedge clk) begin
        xl_rsp_valid = xl_pend;
        xl_rsp_fault = xl_pend & xflt_mode;
        xl_rsp_paddr = xl_pend ? xlat(xl_va) : 64'd0;
        xl_pend      = 1'b0;
        cv_rsp_valid = cv_pend;
        cv_rsp_data  = cv_pend ? conv(cv_sz, cv_i, cv_s) : 128'd0;
        cv_pend      = 1'b0;
        rdy          = stall ? ~rdy : 1'b1;
        xl_ready = rdy; cv_ready = rdy; mw_ready = rdy; ai_ready = rdy;
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        int d0 = done_cnt, x0 = xl_cnt, m0 = mw_cnt, a0 = ai_cnt, w0 = wb_cnt;
        int waitc = 0;
        bit early, ok_path;
        string ftag;
        logic [63:0] exp_wb;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_qp = v.qp; req_spill = v.spill; req_intform = v.intf; req_bupd = v.bupd;
        req_fmt = v.fmt; req_base = v.base; req_base_nat = v.bnat; req_data_natval = v.nval;
        req_reg_dis = v.dis; req_tgt_bad = v.tbad; req_imm = v.imm; xflt_mode = v.xflt;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R11", "ready low while busy", 128'(req_ready), 128'd0);
        while (done_cnt == d0 && waitc < 300) begin
            @(negedge clk);
            waitc++;
        end
        repeat (3) @(negedge clk);

        early   = !v.qp || (v.efault inside {3'd1, 3'd2, 3'd3});
        ok_path = v.qp && v.efault == 3'd0;
        ftag = !v.qp ? "R1" : (v.efault == 3'd1) ? "R2" : (v.efault == 3'd2) ? "R3" :
               (v.efault == 3'd3) ? "R4" : (v.efault == 3'd4) ? "R9" : "R5";
        exp_wb = v.base + {{55{v.imm[8]}}, v.imm};

        chk(done_cnt - d0 == 1, "R12", "done pulses", 128'(done_cnt - d0), 128'd1);
        chk(last_fault == v.efault, ftag, "fault code", 128'(last_fault), 128'(v.efault));
        chk(xl_cnt - x0 == (early ? 0 : 1), early ? "R10" : "R9", "translation requests",
            128'(xl_cnt - x0), 128'(early ? 0 : 1));
        if (!early) begin
            chk(xl_sz == v.esize, "R5", "translation size", 128'(xl_sz), 128'(v.esize));
            chk(xl_uc == (v.esize == 5'd10), "R6", "translation uncache", 128'(xl_uc),
                128'(v.esize == 5'd10));
        end
        chk(mw_cnt - m0 == (ok_path ? 1 : 0), ok_path ? "R7" : ftag, "memory writes",
            128'(mw_cnt - m0), 128'(ok_path ? 1 : 0));
        chk(ai_cnt - a0 == (ok_path ? 1 : 0), "R7", "invalidates",
            128'(ai_cnt - a0), 128'(ok_path ? 1 : 0));
        if (ok_path) begin
            chk(mw_a == xlat(v.base), "R7", "write address", 128'(mw_a), 128'(xlat(v.base)));
            chk(mw_sz == v.esize, "R5", "write size", 128'(mw_sz), 128'(v.esize));
            chk(mw_uc == (v.esize == 5'd10), "R6", "write uncache", 128'(mw_uc),
                128'(v.esize == 5'd10));
            chk(mw_d == conv(v.esize, v.intf, v.spill), "R7", "write data", mw_d,
                conv(v.esize, v.intf, v.spill));
            chk(ai_a == mw_a && ai_sz == mw_sz, "R7", "invalidate range",
                {ai_a, 59'd0, ai_sz}, {mw_a, 59'd0, mw_sz});
        end
        chk(wb_cnt - w0 == ((ok_path && v.bupd) ? 1 : 0), "R8", "writebacks",
            128'(wb_cnt - w0), 128'((ok_path && v.bupd) ? 1 : 0));
        if (ok_path && v.bupd) begin
            chk(wb_d == exp_wb, "R8", "writeback value", 128'(wb_d), 128'(exp_wb));
            chk(wb_n == 1'b0, "R8", "writeback NaT", 128'(wb_n), 128'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R11", "reset ready", 128'(req_ready), 128'd1);
        chk(done == 1'b0, "R12", "reset done", 128'(done), 128'd0);
        chk({xl_valid, cv_valid, mw_valid, ai_valid, wb_valid} == 5'd0, "R1", "reset valids",
            128'({xl_valid, cv_valid, mw_valid, ai_valid, wb_valid}), 128'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // Backpressure on every port
        stall = 1'b1;
        run_vec(VECS[3]);
        run_vec(VECS[7]);
        run_vec(VECS[13]);
        run_vec(VECS[6]);
        stall = 1'b0;

        // Back-to-back after a fault, then a clean store
        run_vec(VECS[9]);
        run_vec(VECS[8]);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule